// File: doc/BRIEF.md
# Register-Mapped Serial Port Controller

This block is an asynchronous serial transmitter and receiver that software drives through five word-indexed registers. A byte written to the transmit data register enters a transmit FIFO. The transmit engine then sends it as a frame with a start bit, 5 to 8 data bits sent least significant bit first, optional parity, and one or two stop bits. The receive engine rebuilds frames from the input line and places the bytes in a receive FIFO, which software empties through the receive data register.

One packed control word holds the whole line setup: the baud divisor, the character length, parity, stop bits and the polarity of each line. Writing it can also fire one-cycle pulses that flush either path or clear the sticky error flags. A status word reports both FIFO fill counts, full and empty flags, three sticky error flags and two busy flags. The baud generator gives one tick every N+1 clocks, and every serial bit lasts exactly four ticks.

Top module: `uart_ctl`

## Requirements
- R1: After reset the control word reads 0, the status word reads 0x0050_0000 (both FIFOs empty, nothing else set), and the TX line is high.
- R2: Index 2 holds the control word. Bits 22, 23 and 24 are pulses that read back as 0; every other written bit reads back as written. Index 4 reads as 0.
- R3: With divisor N in control bits [11:0], every serial bit, the start bit included, lasts 4×(N+1) clocks.
- R4: Control bits [21:20] choose the character length (0: 8 bits, 1: 7, 2: 6, 3: 5). Data travels least significant bit first, and only the low bits of the written byte are sent; the received byte has its unused upper bits at 0.
- R5: Control bit 19 enables a parity bit after the data. Bit 18 selects odd parity (1) or even parity (0). A received parity mismatch sets status bit 16.
- R6: Control bit 16 selects two stop bits (1) or one (0). A low level sampled where the first stop bit should be sets status bit 17.
- R7: Status bits [14:8] and [6:0] give the TX and RX FIFO counts (depth 64). Bits 21/22 flag TX full/empty and bits 19/20 flag RX full/empty. A write to a full TX FIFO is dropped and sets status bit 18. A byte received while the RX FIFO is full is dropped.
- R8: A read of index 1 pops the oldest received byte. A read while the RX FIFO is empty returns 0 and leaves the count at 0.
- R9: Writing the control word with bit 24 set clears status bits 16, 17 and 18.
- R10: Control bit 22 flushes the TX FIFO and aborts any frame being sent. Bit 23 flushes the RX FIFO and abandons any reception in progress.
- R11: Control bit 25 inverts the RX line and bit 26 inverts the TX line, which then idles low.
- R12: Control bit 12 enables sending; while it is clear, queued bytes stay in the TX FIFO. Control bit 13 enables reception; while it is clear, incoming frames are ignored.
- R13: Status bit 25 is set while a frame is being sent and bit 26 while one is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; pops the RX FIFO at index 1 |
| addr | input | 3 | Register word index 0..4 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
A wrong framing state shows up within one character time: loopback bytes come back with bits shifted or masked wrongly, or with a false parity or framing flag. A fault in a bit-counter or tick shows up within a single bit time, as a start-bit width or stop gap measured on tx_o that differs from the 4×(N+1) arithmetic. A FIFO pointer fault shows up at once in the status counts and full/empty flags, or when the wrong byte is popped from index 1.

// File: rtl/uart_ctl.sv
module uart_ctl #(
  parameter int DIV_W = 12,
  parameter int AW    = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        rx_i,
  output logic        tx_o
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] ctrl_q;
  logic [DIV_W-1:0] bcnt;
  logic [7:0] tmem [DEPTH];
  logic [7:0] rmem [DEPTH];
  logic [AW:0] twp, trp, rwp, rrp;
  logic [11:0] tsh;
  logic [3:0]  tbits, ridx;
  logic [1:0]  tq, rq, rs;
  logic [7:0]  rsh;
  logic        rbusy, rpx, perr, ferr, werr;
  logic [11:0] tframe;

  wire [DIV_W-1:0] div = ctrl_q[DIV_W-1:0];
  wire tick   = bcnt >= div;
  wire wr_tx  = wr_en && addr == 3'd0;
  wire wr_ctl = wr_en && addr == 3'd2;
  wire rd_rx  = rd_en && addr == 3'd1;
  wire txrst  = wr_ctl && wdata[22];
  wire rxrst  = wr_ctl && wdata[23];
  wire clrerr = wr_ctl && wdata[24];

  wire [3:0] clen = 4'd8 - {2'b00, ctrl_q[21:20]};
  wire pen  = ctrl_q[19];
  wire podd = ctrl_q[18];
  wire stp2 = ctrl_q[16];
  wire r    = rs[1];

  wire [AW:0] tcnt = twp - trp;
  wire [AW:0] rcnt = rwp - rrp;
  wire tfull  = tcnt[AW];
  wire tempty = tcnt == '0;
  wire rfull  = rcnt[AW];
  wire rempty = rcnt == '0;
  wire tbusy  = tbits != 4'd0;

  wire [7:0] tdm  = tmem[trp[AW-1:0]] & (8'hFF >> ctrl_q[21:20]);
  wire [3:0] tlen = 4'd2 + clen + {3'b000, pen} + {3'b000, stp2};
  wire tstart = tick && !tbusy && !tempty && ctrl_q[12];

  wire [3:0] sidx  = clen + 4'd1 + {3'b000, pen};
  wire rsample = tick && rbusy && rq == 2'd2;
  wire rpush   = rsample && ridx == sidx && !rfull;
  wire [7:0] rbyte = rsh >> (4'd8 - clen);

  always_comb begin
    tframe = '1;
    tframe[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (4'(i) < clen) tframe[i+1] = tdm[i];
    if (pen) tframe[clen + 4'd1] = ^tdm ^ podd;
  end

  assign tx_o = (tbusy ? tsh[0] : 1'b1) ^ ctrl_q[26];

  always_comb begin
    rdata = '0;
    case (addr)
      3'd1: rdata = rempty ? 32'd0 : {24'd0, rmem[rrp[AW-1:0]]};
      3'd2: rdata = ctrl_q;
      3'd3: begin
        rdata[6:0]  = 7'(rcnt);
        rdata[14:8] = 7'(tcnt);
        rdata[16] = perr;
        rdata[17] = ferr;
        rdata[18] = werr;
        rdata[19] = rfull;
        rdata[20] = rempty;
        rdata[21] = tfull;
        rdata[22] = tempty;
        rdata[25] = tbusy;
        rdata[26] = rbusy;
      end
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_tx && !tfull) tmem[twp[AW-1:0]] <= wdata[7:0];
    if (rpush) rmem[rwp[AW-1:0]] <= rbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; bcnt <= '0; rs <= 2'b11;
      twp <= '0; trp <= '0; rwp <= '0; rrp <= '0;
      tsh <= '1; tbits <= '0; tq <= '0;
      rbusy <= 1'b0; rq <= '0; ridx <= '0; rsh <= '0; rpx <= 1'b0;
      perr <= 1'b0; ferr <= 1'b0; werr <= 1'b0;
    end else begin
      rs   <= {rs[0], rx_i ^ ctrl_q[25]};
      bcnt <= tick ? '0 : bcnt + 1'b1;
      if (wr_ctl) ctrl_q <= wdata & ~32'h01C0_0000;

      if (wr_tx) begin
        if (tfull) werr <= 1'b1;
        else twp <= twp + 1'b1;
      end

      if (tstart) begin
        tsh <= tframe; tbits <= tlen; tq <= '0; trp <= trp + 1'b1;
      end else if (tick && tbusy) begin
        tq <= tq + 1'b1;
        if (tq == 2'd3) begin
          tsh <= {1'b1, tsh[11:1]};
          tbits <= tbits - 1'b1;
        end
      end

      if (rd_rx && !rempty) rrp <= rrp + 1'b1;

      if (tick) begin
        if (!rbusy) begin
          if (ctrl_q[13] && !r) begin
            rbusy <= 1'b1; rq <= 2'd1; ridx <= '0; rpx <= 1'b0;
          end
        end else begin
          rq <= rq + 1'b1;
          if (rq == 2'd2) begin
            ridx <= ridx + 1'b1;
            if (ridx == 4'd0) begin
              if (r) rbusy <= 1'b0;
            end else if (ridx <= clen) begin
              rsh <= {r, rsh[7:1]};
              rpx <= rpx ^ r;
            end else if (ridx != sidx) begin
              if ((rpx ^ r) != podd) perr <= 1'b1;
            end else begin
              if (!r) ferr <= 1'b1;
              if (!rfull) rwp <= rwp + 1'b1;
              rbusy <= 1'b0;
            end
          end
        end
      end

      if (txrst) begin twp <= '0; trp <= '0; tbits <= '0; end
      if (rxrst) begin rwp <= '0; rrp <= '0; rbusy <= 1'b0; end
      if (clrerr) begin perr <= 1'b0; ferr <= 1'b0; werr <= 1'b0; end
    end
  end
endmodule

// File: rtl/uart_ctl_chk.sv
module uart_ctl_chk #(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [2:0]  addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        tx_o,
  input logic        inv_tx,
  input logic        tbusy,
  input logic        perr,
  input logic        ferr,
  input logic [AW:0] tcnt,
  input logic [AW:0] rcnt
);
  localparam int DEPTH = 1 << AW;

  a_r13_space_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_o == inv_tx) |-> tbusy);

  a_r7_tx_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tcnt) <= DEPTH);

  a_r8_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd1 && rcnt == '0) |-> rdata == 32'd0);

  a_r9_clear_errors: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && wdata[24]) |=> (!perr && !ferr));

  a_r10_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2 && wdata[22]) |=> (tcnt == '0 && !tbusy));

  a_r2_pulses_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 3'd2) |-> rdata[24:22] == 3'b000);
endmodule

bind uart_ctl uart_ctl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .tx_o(tx_o), .inv_tx(ctrl_q[26]),
  .tbusy(tbusy), .perr(perr), .ferr(ferr), .tcnt(tcnt), .rcnt(rcnt)
);

// File: tb/sim_uart_ctl.sv
module sim_uart_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic tx_o;
  logic lb = 1'b1;
  logic rx_drv = 1'b1;
  wire rx_i = lb ? tx_o : rx_drv;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  uart_ctl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rx_i(rx_i), .tx_o(tx_o));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [11:0] f, input int nb);
    for (int i = 0; i < nb; i++) begin
      rx_drv = f[i];
      repeat (16) @(negedge clk);
    end
    rx_drv = 1'b1;
  endtask

  localparam logic [31:0] PULSES = 32'h01C0_0000;

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    idle(3); rst_n = 1'b1; idle(2);

    rd(3'd3, v); chk(v == 32'h0050_0000, "R1 status", v, 32'h0050_0000);
    rd(3'd2, v); chk(v == 32'd0, "R1 ctrl", v, 0);
    chk(tx_o == 1'b1, "R1 tx idle", {31'd0, tx_o}, 1);

    wr(3'd2, 32'h01FF_F123);
    rd(3'd2, v); chk(v == 32'h003F_F123, "R2 ctrl readback", v, 32'h003F_F123);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk(v == 32'd0, "R2 misc reads zero", v, 0);

    for (int nd = 1; nd <= 3; nd += 2) begin
      wr(3'd2, PULSES | 32'h1000 | nd);
      wr(3'd0, 32'hFF);
      n = 0;
      while (tx_o && n < 100) begin @(negedge clk); n++; end
      n = 0;
      while (!tx_o && n < 200) begin @(negedge clk); n++; end
      chk(n == 4 * (nd + 1), "R3 start bit width", n, 4 * (nd + 1));
      idle(200);
    end

    for (int s = 0; s < 2; s++) begin
      wr(3'd2, PULSES | 32'h1001 | (s << 16));
      wr(3'd0, 32'h00); wr(3'd0, 32'h00);
      n = 0;
      while (tx_o && n < 100) begin @(negedge clk); n++; end
      n = 0;
      while (!tx_o && n < 200) begin @(negedge clk); n++; end
      n = 0;
      while (tx_o && n < 200) begin @(negedge clk); n++; end
      chk(n == 8 * (s + 1) + 2, "R6 stop gap", n, 8 * (s + 1) + 2);
      idle(300);
    end

    for (int lc = 0; lc < 4; lc++)
      for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++) begin
          logic [31:0] cw;
          logic [7:0] m;
          cw = PULSES | 32'h3003 | (s << 16) | (lc << 20);
          if (p == 1) cw |= 32'h0008_0000;
          if (p == 2) cw |= 32'h000C_0000;
          wr(3'd2, cw);
          for (int k = 0; k < 3; k++) wr(3'd0, (k * 37 + lc * 53 + p * 11 + s * 7 + 5) & 8'hFF);
          idle(800);
          rd(3'd3, v);
          chk(v[6:0] == 7'd3 && v[18:16] == 3'b000, "R5 R6 loopback status", v, 32'h3);
          m = 8'hFF >> lc;
          for (int k = 0; k < 3; k++) begin
            logic [7:0] e;
            e = 8'((k * 37 + lc * 53 + p * 11 + s * 7 + 5) & 8'hFF) & m;
            rd(3'd1, v);
            chk(v == {24'd0, e}, "R4 loopback data", v, {24'd0, e});
          end
        end

    lb = 1'b0;
    wr(3'd2, PULSES | 32'h0008_2003);
    drive_frame({1'b1, 1'b1, 8'h5A, 1'b0}, 11);
    idle(40);
    rd(3'd3, v); chk(v[17:16] == 2'b01, "R5 parity error flag", v, 32'h0001_0000);
    rd(3'd1, v); chk(v == 32'h5A, "R5 byte kept", v, 32'h5A);
    wr(3'd2, 32'h0108_2003);
    rd(3'd3, v); chk(v[18:16] == 3'b000, "R9 clear errors", v, 0);
    drive_frame({1'b0, 1'b0, 8'h5A, 1'b0}, 11);
    idle(200);
    rd(3'd3, v); chk(v[17] == 1'b1, "R6 framing error flag", v, 32'h0002_0000);
    wr(3'd2, PULSES | 32'h0000_2003);

    wr(3'd2, PULSES | 32'h0000_1003);
    drive_frame({1'b1, 1'b1, 8'h33, 1'b0}, 11);
    idle(40);
    rd(3'd3, v); chk(v[6:0] == 7'd0, "R12 rx disabled ignores", v, 0);
    lb = 1'b1;

    wr(3'd2, PULSES | 32'h0000_2003);
    for (int k = 0; k < 64; k++) wr(3'd0, k);
    idle(100);
    rd(3'd3, v); chk(v[14:8] == 7'd64 && v[21] && !v[22], "R7 R12 tx full held", v, 32'h0020_4000);
    wr(3'd0, 32'hAA);
    rd(3'd3, v); chk(v[18] && v[14:8] == 7'd64, "R7 overflow error", v, 32'h0004_4000);
    wr(3'd2, PULSES | 32'h0000_2003);
    rd(3'd3, v); chk(v[14:8] == 7'd0 && v[22] && !v[18], "R10 tx flush", v, 32'h0040_0000);

    wr(3'd2, PULSES | 32'h0000_3003);
    for (int k = 0; k < 40; k++) wr(3'd0, k + 16);
    idle(40 * 200);
    for (int k = 40; k < 66; k++) wr(3'd0, k + 16);
    idle(26 * 200 + 200);
    rd(3'd3, v); chk(v[6:0] == 7'd64 && v[19] && !v[20] && v[22], "R7 rx full", v, 32'h0048_0040);
    rd(3'd1, v); chk(v == 32'd16, "R8 oldest byte", v, 16);
    rd(3'd3, v); chk(v[6:0] == 7'd63, "R8 pop count", v, 63);
    wr(3'd2, PULSES | 32'h0000_3003);
    rd(3'd3, v); chk(v[6:0] == 7'd0 && v[20], "R10 rx flush", v, 32'h0010_0000);
    rd(3'd1, v); chk(v == 32'd0, "R8 empty read zero", v, 0);
    rd(3'd3, v); chk(v[6:0] == 7'd0, "R8 empty count kept", v, 0);

    wr(3'd2, PULSES | 32'h0600_3003);
    idle(2);
    chk(tx_o == 1'b0, "R11 inverted idle", {31'd0, tx_o}, 0);
    wr(3'd0, 32'hC3);
    idle(20);
    rd(3'd3, v); chk(v[25] && v[26], "R13 busy flags", v, 32'h0600_0000);
    idle(300);
    rd(3'd3, v); chk(!v[25] && !v[26], "R13 busy cleared", v, 0);
    rd(3'd1, v); chk(v == 32'hC3, "R11 inverted loopback", v, 32'hC3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule